// File: doc/BRIEF.md
# Late-Late-Write Buffer with Byte-Lane Bypass

This block is the write and read datapath of a pipelined synchronous memory whose write data trails its command by two active clock cycles. A write's address and byte enables are taken on the edge that issues it, and its data is taken from the data input two active edges later. Because the write data trails its command, reads and writes can follow each other on every cycle with no turnaround gap. Writes wait in a small ordered buffer. The oldest finished write is copied into a single-port array only when a later write is issued, because that is the one edge on which the array port is known to be free of reads.

Each read looks up its address in the array and in every buffered write, including a write whose data arrives on the same edge. It replaces each enabled byte lane with the newest matching write, so the read always returns the last data written to that address. A low clock enable freezes the whole pipeline. While it is low, no command is taken, no data is captured and the read outputs keep their values.

Top module: `llw_mem`

## Requirements
- R1: A read issued on active edge N drives `rvalid` high after active edge N+1. `rvalid` is low after every active edge that does not follow a read issue.
- R2: A write's address and byte enables are taken on its issue edge. Its data is taken from `wdata` on the second active edge after issue, and `wdata` is ignored on all other edges.
- R3: `byte_wen_n` is active low, and bit i controls bits [8i+7:8i]. A write with all four bits high is an abort: it changes neither the array nor the buffer.
- R4: A read issued on the edge right after a write to the same address returns that write's data. In this case the data is captured on the same edge as the read merge.
- R5: In a read result, each byte lane enabled by a matching buffered write comes from that write. Each other lane comes from the array.
- R6: When several buffered writes match a read, each lane takes the value of the most recently issued write that enabled it.
- R7: A buffered write is copied to the array only on the issue edge of a later non-aborted write. After the copy, its data stays readable.
- R8: While `clk_en` is low, no command or data is taken and `rdata` and `rvalid` hold their values. A write's data capture moves back by one cycle for each stalled cycle.
- R9: After reset, `rvalid` and `rdata` are 0 and the buffer is empty. Array contents written before reset are kept.
- R10: A read whose merge edge is the same edge on which its matching entry is copied to the array returns the new bytes.
- R11: The buffer never holds more than three writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| clk_en | input | 1 | Cycle enable; low stalls the whole pipeline |
| cmd_vld | input | 1 | A command is issued this cycle |
| cmd_rd | input | 1 | 1 = read, 0 = write |
| addr | input | ADDR_W | Word address of the command |
| byte_wen_n | input | 4 | Active-low byte write enables |
| wdata | input | 32 | Write data for the write issued two active edges earlier |
| rdata | output | 32 | Read result |
| rvalid | output | 1 | `rdata` holds a new read result |

## Verification
A read result is due one active edge after the read's issue edge. A write's data is due two active edges after its issue. The bench therefore counts only active edges: stalled cycles advance neither its write-data pipeline nor its pending-read slot. Every result is sampled on the falling edge after the active edge that produces it. The expected value comes from a word model that the bench updates at write issue, in program order, so any late data or missed bypass shows up on the first read that follows.

// File: rtl/llw_pkg.sv
// Shared lane geometry and the byte-lane merge helper.
package llw_pkg;
    localparam int LANES  = 4;
    localparam int LANE_W = 8;
    localparam int WORD_W = LANES * LANE_W;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [LANES-1:0]  mask_t;

    // Replace every lane of base selected by sel with the lane from over.
    function automatic word_t lane_merge(word_t base, mask_t sel, word_t over);
        word_t r;
        r = base;
        for (int l = 0; l < LANES; l++) begin
            if (sel[l]) r[l*LANE_W +: LANE_W] = over[l*LANE_W +: LANE_W];
        end
        return r;
    endfunction
endpackage

// File: rtl/llw_array.sv
// Single-port synchronous word array with per-lane write masks.
// Assumes at most one access per enabled edge; read data is registered and
// holds between reads. Contents are not reset.
module llw_array
    import llw_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DEPTH  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              en,
    input  logic              we,
    input  mask_t             wmask,
    input  logic [ADDR_W-1:0] addr,
    input  word_t             wdat,
    output word_t             q
);
    word_t mem [DEPTH];

    // One access per edge: masked lane write, or registered read.
    always_ff @(posedge clk) begin
        if (en) begin
            if (we) begin
                for (int l = 0; l < LANES; l++) begin
                    if (wmask[l]) mem[addr][l*LANE_W +: LANE_W] <= wdat[l*LANE_W +: LANE_W];
                end
            end else begin
                q <= mem[addr];
            end
        end
    end
endmodule

// File: rtl/llw_wbuf.sv
// Ordered holding buffer for writes whose data trails the command.
// Slot 0 is the oldest entry. Each entry counts active edges down to its
// data capture; the head leaves only once complete and when commit_req is set.
// The lookup port merges all matching, data-bearing entries from oldest to newest;
// an entry whose data is captured this edge supplies the live wdata lanes.
module llw_wbuf
    import llw_pkg::*;
#(
    parameter int ADDR_W   = 6,
    parameter int SLOTS    = 3,
    parameter int DATA_LAG = 2,
    localparam int CNT_W   = $clog2(SLOTS + 2),
    localparam int DUE_W   = $clog2(DATA_LAG + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              alloc,
    input  logic [ADDR_W-1:0] alloc_addr,
    input  mask_t             alloc_mask,
    input  word_t             wdata,
    input  logic              commit_req,
    output logic              cm_fire,
    output logic [ADDR_W-1:0] cm_addr,
    output mask_t             cm_mask,
    output word_t             cm_data,
    input  logic [ADDR_W-1:0] lk_addr,
    output mask_t             lk_mask,
    output word_t             lk_data,
    output logic [CNT_W-1:0]  occupancy
);
    logic [ADDR_W-1:0] s_a   [SLOTS];
    mask_t             s_m   [SLOTS];
    word_t             s_d   [SLOTS];
    logic [DUE_W-1:0]  s_due [SLOTS];
    logic [CNT_W-1:0]  cnt;

    logic [ADDR_W-1:0] g_a   [SLOTS];
    mask_t             g_m   [SLOTS];
    word_t             g_d   [SLOTS];
    logic [DUE_W-1:0]  g_due [SLOTS];
    logic [ADDR_W-1:0] n_a   [SLOTS];
    mask_t             n_m   [SLOTS];
    word_t             n_d   [SLOTS];
    logic [DUE_W-1:0]  n_due [SLOTS];
    logic [CNT_W-1:0]  cnt_mid, cnt_nx;

    assign cm_fire   = commit_req && (cnt != '0) && (s_due[0] == '0);
    assign cm_addr   = s_a[0];
    assign cm_mask   = s_m[0];
    assign cm_data   = s_d[0];
    assign occupancy = cnt;

    // Next state: age and capture, then pop the head, then append at the tail.
    always_comb begin
        for (int i = 0; i < SLOTS; i++) begin
            g_a[i] = s_a[i]; g_m[i] = s_m[i]; g_d[i] = s_d[i]; g_due[i] = s_due[i];
            if ((CNT_W'(i) < cnt) && (s_due[i] != '0)) begin
                g_due[i] = s_due[i] - 1'b1;
                if (s_due[i] == DUE_W'(1)) g_d[i] = wdata;
            end
        end
        for (int i = 0; i < SLOTS; i++) begin
            n_a[i] = g_a[i]; n_m[i] = g_m[i]; n_d[i] = g_d[i]; n_due[i] = g_due[i];
        end
        cnt_mid = cnt;
        if (cm_fire) begin
            for (int i = 0; i < SLOTS - 1; i++) begin
                n_a[i] = g_a[i+1]; n_m[i] = g_m[i+1]; n_d[i] = g_d[i+1]; n_due[i] = g_due[i+1];
            end
            n_a[SLOTS-1] = '0; n_m[SLOTS-1] = '0; n_d[SLOTS-1] = '0; n_due[SLOTS-1] = '0;
            cnt_mid = cnt - 1'b1;
        end
        cnt_nx = cnt_mid;
        if (alloc) begin
            for (int j = 0; j < SLOTS; j++) begin
                if (CNT_W'(j) == cnt_mid) begin
                    n_a[j] = alloc_addr; n_m[j] = alloc_mask;
                    n_d[j] = '0;         n_due[j] = DUE_W'(DATA_LAG);
                end
            end
            cnt_nx = cnt_mid + 1'b1;
        end
    end

    // Register the buffer on active edges only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            for (int i = 0; i < SLOTS; i++) begin
                s_a[i] <= '0; s_m[i] <= '0; s_d[i] <= '0; s_due[i] <= '0;
            end
        end else if (step) begin
            cnt <= cnt_nx;
            for (int i = 0; i < SLOTS; i++) begin
                s_a[i] <= n_a[i]; s_m[i] <= n_m[i]; s_d[i] <= n_d[i]; s_due[i] <= n_due[i];
            end
        end
    end

    // Bypass lookup: newest matching entry wins per lane.
    always_comb begin
        lk_mask = '0;
        lk_data = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if ((CNT_W'(i) < cnt) && (s_a[i] == lk_addr) && (s_due[i] <= DUE_W'(1))) begin
                lk_mask = lk_mask | s_m[i];
                lk_data = lane_merge(lk_data, s_m[i], (s_due[i] == DUE_W'(1)) ? wdata : s_d[i]);
            end
        end
    end
endmodule

// File: rtl/llw_mem.sv
// Memory datapath with two-edge-late write data and byte-lane read bypass.
// Reads use the array port on their issue edge and merge buffered bytes on
// the next active edge. Buffered writes reach the array only on the issue edge
// of a later non-aborted write, so the port never sees two accesses at once.
// Assumes clk_en is low only to stall; all state holds while it is low.
module llw_mem
    import llw_pkg::*;
#(
    parameter int ADDR_W   = 6,
    parameter int SLOTS    = 3,
    parameter int DATA_LAG = 2,
    localparam int CNT_W   = $clog2(SLOTS + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic              cmd_vld,
    input  logic              cmd_rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  byte_wen_n,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output logic              rvalid
);
    mask_t             wmask;
    logic              rd_issue, wr_alloc;
    logic              cm_fire;
    logic [ADDR_W-1:0] cm_addr;
    mask_t             cm_mask;
    word_t             cm_data;
    mask_t             lk_mask;
    word_t             lk_data;
    logic [CNT_W-1:0]  buf_cnt;
    word_t             arr_q;
    logic              rd_pend;
    logic [ADDR_W-1:0] rd_addr_q;

    assign wmask    = ~byte_wen_n;
    assign rd_issue = clk_en && cmd_vld && cmd_rd;
    assign wr_alloc = clk_en && cmd_vld && !cmd_rd && (wmask != '0);

    llw_wbuf #(.ADDR_W(ADDR_W), .SLOTS(SLOTS), .DATA_LAG(DATA_LAG)) u_wbuf (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (clk_en),
        .alloc      (wr_alloc),
        .alloc_addr (addr),
        .alloc_mask (wmask),
        .wdata      (wdata),
        .commit_req (wr_alloc),
        .cm_fire    (cm_fire),
        .cm_addr    (cm_addr),
        .cm_mask    (cm_mask),
        .cm_data    (cm_data),
        .lk_addr    (rd_addr_q),
        .lk_mask    (lk_mask),
        .lk_data    (lk_data),
        .occupancy  (buf_cnt)
    );

    llw_array #(.ADDR_W(ADDR_W)) u_array (
        .clk   (clk),
        .en    (rd_issue || cm_fire),
        .we    (cm_fire),
        .wmask (cm_mask),
        .addr  (cm_fire ? cm_addr : addr),
        .wdat  (cm_data),
        .q     (arr_q)
    );

    // Read pipeline: note the read on issue, merge and present one active edge later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_pend   <= 1'b0;
            rd_addr_q <= '0;
            rdata     <= '0;
            rvalid    <= 1'b0;
        end else if (clk_en) begin
            rd_pend <= rd_issue;
            if (rd_issue) rd_addr_q <= addr;
            rvalid  <= rd_pend;
            if (rd_pend) rdata <= lane_merge(arr_q, lk_mask, lk_data);
        end
    end
endmodule

// File: rtl/llw_mem_chk.sv
// Timing and buffer-bound properties for llw_mem, attached by bind.
module llw_mem_chk #(
    parameter int SLOTS = 3,
    parameter int CNT_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clk_en,
    input logic             cmd_vld,
    input logic             cmd_rd,
    input logic [3:0]       byte_wen_n,
    input logic [31:0]      rdata,
    input logic             rvalid,
    input logic [CNT_W-1:0] occupancy,
    input logic             cm_fire
);
    logic pend_c, exp_rv;

    // Track which active edge owes a read result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_c <= 1'b0;
            exp_rv <= 1'b0;
        end else if (clk_en) begin
            pend_c <= cmd_vld && cmd_rd;
            exp_rv <= pend_c;
        end
    end

    AST_RVALID_SLOT: assert property (@(posedge clk) disable iff (!rst_n) rvalid == exp_rv); // R1
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> ($stable(rdata) && $stable(rvalid))); // R8
    AST_ABORT_NO_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && cmd_vld && !cmd_rd && (&byte_wen_n)) |=> $stable(occupancy)); // R3
    AST_COMMIT_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        cm_fire |-> (clk_en && cmd_vld && !cmd_rd && !(&byte_wen_n))); // R7
    AST_COMMIT_HAS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        cm_fire |-> (occupancy != '0)); // R7
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        occupancy <= CNT_W'(SLOTS)); // R11
endmodule

bind llw_mem llw_mem_chk #(.SLOTS(SLOTS), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clk_en     (clk_en),
    .cmd_vld    (cmd_vld),
    .cmd_rd     (cmd_rd),
    .byte_wen_n (byte_wen_n),
    .rdata      (rdata),
    .rvalid     (rvalid),
    .occupancy  (buf_cnt),
    .cm_fire    (cm_fire)
);

// File: tb/sim_llw_mem.sv
module sim_llw_mem;
    localparam int AW = 6;
    localparam logic [31:0] JUNK = 32'hA5A5_5A5A;
    localparam int OP_IDLE = 0, OP_RD = 1, OP_WR = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clk_en = 1'b1;
    logic        cmd_vld = 1'b0;
    logic        cmd_rd = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [3:0]  byte_wen_n = 4'hF;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rvalid;

    int n_run = 0;
    int n_fail = 0;

    logic [31:0] mdl [64];
    logic [31:0] d1 = JUNK, d2 = JUNK;
    logic        rp = 1'b0;
    logic [31:0] rexp = '0;
    logic [31:0] last_q = '0;
    string       rtag = "";

    llw_mem #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .cmd_vld(cmd_vld), .cmd_rd(cmd_rd),
        .addr(addr), .byte_wen_n(byte_wen_n), .wdata(wdata), .rdata(rdata), .rvalid(rvalid)
    );

    always #10 clk = ~clk;

    task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string req);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %h exp %h", req, got, exp);
        end
    endtask

    // One clock cycle: drive, pass the edge, check on the falling edge.
    task automatic cyc(input logic en, input int op, input logic [AW-1:0] a,
                       input logic [3:0] nm, input logic [31:0] d, input string req);
        clk_en     = en;
        cmd_vld    = (op != OP_IDLE);
        cmd_rd     = (op == OP_RD);
        addr       = a;
        byte_wen_n = nm;
        wdata      = en ? d2 : JUNK;
        @(posedge clk);
        @(negedge clk);
        if (en) begin
            if (rp) begin
                chk({31'd0, rvalid}, 32'd1, {rtag, " rvalid"});
                chk(rdata, rexp, rtag);
                last_q = rexp;
            end else begin
                chk({31'd0, rvalid}, 32'd0, "R1 idle rvalid");
            end
            rp = 1'b0;
            d2 = d1;
            d1 = (op == OP_WR) ? d : JUNK;
            if (op == OP_RD) begin
                rp = 1'b1; rexp = mdl[a]; rtag = req;
            end
            if (op == OP_WR) begin
                for (int l = 0; l < 4; l++) if (!nm[l]) mdl[a][l*8 +: 8] = d[l*8 +: 8];
            end
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; cmd_vld = 1'b0; clk_en = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        d1 = JUNK; d2 = JUNK; rp = 1'b0;
        chk({31'd0, rvalid}, 32'd0, "R9 rvalid");
        chk(rdata, 32'd0, "R9 rdata");
    endtask

    task automatic t_fill();
        for (int i = 0; i < 64; i++) cyc(1, OP_WR, AW'(i), 4'h0, 32'h5A00_0000 ^ (i * 32'h0101_0101), "R2");
        for (int i = 0; i < 8; i++) cyc(1, OP_RD, AW'(i * 5), 4'hF, 0, "R2 fill readback");
        cyc(1, OP_IDLE, 0, 4'hF, 0, "");
    endtask

    task automatic t_commit_same();
        do_reset();
        cyc(1, OP_WR, 6'd5, 4'h0, 32'hC0DE_0005, "R10");
        cyc(1, OP_RD, 6'd9, 4'hF, 0, "R9 array kept over reset");
        cyc(1, OP_RD, 6'd5, 4'hF, 0, "R10 bypass at commit edge");
        cyc(1, OP_WR, 6'd9, 4'h0, 32'h9999_0009, "R10");
        cyc(1, OP_IDLE, 0, 4'hF, 0, "");
        cyc(1, OP_RD, 6'd5, 4'hF, 0, "R7 after commit");
        cyc(1, OP_IDLE, 0, 4'hF, 0, "");
    endtask

    task automatic t_raw();
        cyc(1, OP_WR, 6'd12, 4'h0, 32'h1122_3344, "R4");
        cyc(1, OP_RD, 6'd12, 4'hF, 0, "R4 read right after write");
        cyc(1, OP_WR, 6'd12, 4'b1010, 32'hEEDD_CCBB, "R5");
        cyc(1, OP_RD, 6'd12, 4'hF, 0, "R5 lanes 0 and 2 merged");
        cyc(1, OP_IDLE, 0, 4'hF, 0, "");
        cyc(1, OP_RD, 6'd12, 4'hF, 0, "R5 settled");
        cyc(1, OP_IDLE, 0, 4'hF, 0, "");
    endtask

    task automatic t_newest();
        cyc(1, OP_WR, 6'd20, 4'h0, 32'hAAAA_AAAA, "R6");
        cyc(1, OP_WR, 6'd20, 4'b1100, 32'hBBBB_BBBB, "R6");
        cyc(1, OP_WR, 6'd20, 4'b1110, 32'hCCCC_CCCC, "R6");
        cyc(1, OP_RD, 6'd20, 4'hF, 0, "R6 newest lane wins");
        cyc(1, OP_RD, 6'd20, 4'hF, 0, "R6 second read");
        cyc(1, OP_IDLE, 0, 4'hF, 0, "");
    endtask

    task automatic t_abort();
        cyc(1, OP_WR, 6'd30, 4'hF, 32'hDEAD_DEAD, "R3");
        cyc(1, OP_IDLE, 0, 4'hF, 0, "");
        cyc(1, OP_RD, 6'd30, 4'hF, 0, "R3 abort left word");
        cyc(1, OP_WR, 6'd30, 4'b0111, 32'h7700_0000, "R3");
        cyc(1, OP_RD, 6'd30, 4'hF, 0, "R3 lane 3 only");
        cyc(1, OP_IDLE, 0, 4'hF, 0, "");
    endtask

    task automatic t_burst();
        for (int i = 0; i < 6; i++) cyc(1, OP_WR, AW'(40 + i), 4'h0, 32'h4000_0000 + i, "R11");
        for (int i = 0; i < 6; i++) cyc(1, OP_RD, AW'(40 + i), 4'hF, 0, "R11 back-to-back");
        cyc(1, OP_IDLE, 0, 4'hF, 0, "");
    endtask

    task automatic t_stall();
        cyc(1, OP_WR, 6'd25, 4'h0, 32'h2525_A0A0, "R8");
        cyc(0, OP_WR, 6'd26, 4'h0, 0, "");
        cyc(0, OP_IDLE, 0, 4'hF, 0, "");
        cyc(1, OP_IDLE, 0, 4'hF, 0, "");
        cyc(1, OP_RD, 6'd25, 4'hF, 0, "R8 capture deferred");
        cyc(0, OP_RD, 6'd26, 4'hF, 0, "");
        cyc(1, OP_IDLE, 0, 4'hF, 0, "");
        for (int k = 0; k < 2; k++) begin
            cyc(0, OP_IDLE, 0, 4'hF, 0, "");
            chk({31'd0, rvalid}, 32'd1, "R8 rvalid held");
            chk(rdata, last_q, "R8 rdata held");
        end
        cyc(1, OP_RD, 6'd26, 4'hF, 0, "R8 stalled command ignored");
        cyc(1, OP_IDLE, 0, 4'hF, 0, "");
    endtask

    task automatic t_mix();
        logic [15:0] lf = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            cyc(lf[3:0] != 4'h0, (lf[5:4] == 2'd0) ? OP_IDLE : ((lf[5:4] == 2'd1) ? OP_RD : OP_WR),
                AW'(lf[7:6]), lf[11:8], {lf, ~lf}, "R6 mixed traffic");
        end
        cyc(1, OP_IDLE, 0, 4'hF, 0, "");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        do_reset();
        t_fill();
        t_commit_same();
        t_raw();
        t_newest();
        t_abort();
        t_burst();
        t_stall();
        t_mix();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog got timeout exp finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule